// File: doc/BRIEF.md
# Receive Word-to-Byte Unpacker

This block empties a receive FIFO whose 32-bit slots each hold one received word, and turns those words into an ordered byte stream. Software or a sequencer sets a word size of one, two or four bytes, a number of words to drain and a receive length in bytes, then pulses `start`. The block pops one word at a time. Before each pop it checks the FIFO's not-empty flag. The read data arrives one cycle after the pop. The block slices the word into bytes, most significant used byte first. A received word sits right-justified in its slot, so the bytes in use are always the low ones.

Every programmed word is popped while the FIFO has data. Stream positions at or beyond the receive length are dropped, so phantom words that a full-duplex transfer leaves behind still get drained. If the FIFO runs dry before all words are read, the pass ends early and a flag records this. A pass always ends with a one-cycle `done` pulse. More data needs a new `start`.

The byte output is valid/ready. `out_valid` rises only for a kept byte. Once raised, `out_valid`, `out_byte` and `out_index` hold until a cycle with `out_ready` high. Back-pressure stalls the pass and no byte is lost. Dropped bytes take one cycle each and never assert `out_valid`.

Top module: `rx_unpack`

## Requirements
- R1: With word size code 0 (one byte), each popped word gives exactly one stream byte, taken from bits 7:0.
- R2: With word size code 1 (two bytes), each popped word gives bits 15:8 and then bits 7:0.
- R3: With word size code 2 or 3 (four bytes), each popped word gives bits 31:24, 23:16, 15:8 and then 7:0.
- R4: `fifo_pop` is asserted only while `fifo_not_empty` is high. If the FIFO is empty while words remain, the pass ends, `ran_dry` is set and `done` pulses.
- R5: The number of pops in a pass equals the smaller of the programmed word count and the words available, even when the receive length is reached earlier.
- R6: Only stream positions below the latched receive length are presented. `out_index` is the position within the pass, counting from 0.
- R7: `done` is high for exactly one cycle per pass, and `busy` is low in the cycle after it.
- R8: `delivered` equals the number of bytes accepted in the last pass and holds until the next `start`. It never exceeds the receive length.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_index` hold their values into the next cycle.
- R10: The FIFO read is registered. The data word is taken in the cycle after a pop, so `fifo_pop` is never high in two consecutive cycles.
- R11: After reset the block is idle: `busy`, `done`, `out_valid`, `fifo_pop` and `ran_dry` are low and `delivered` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when idle; latches the configuration |
| word_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes per word |
| num_words | input | WCNT_W | Words to drain in the pass |
| rx_len | input | POS_W | Bytes to deliver in the pass |
| fifo_not_empty | input | 1 | FIFO holds at least one word |
| fifo_pop | output | 1 | Read request to the FIFO |
| fifo_rdata | input | 32 | FIFO read data, valid the cycle after a pop |
| out_valid | output | 1 | Byte offered on the output |
| out_ready | input | 1 | Sink accepts the offered byte |
| out_byte | output | 8 | Offered byte |
| out_index | output | POS_W | Stream position of the offered byte |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| delivered | output | POS_W | Bytes accepted in the last pass |
| ran_dry | output | 1 | Last pass ended early on an empty FIFO |

## Verification
The bench sweeps every word-size code against word counts from zero to five. It uses receive lengths of zero, one, one short of the stream, exactly the stream, and past it. This separates byte-lane selection per size from the length cut-off, and it shows whether phantom words are still drained. Each setting runs twice: once with the FIFO holding all the words and once with it holding about half. The half-full runs show whether the block stops and flags correctly rather than popping blindly. Runs alternate between a sink that is always ready and one that stalls in a pseudo-random pattern, so any byte dropped or duplicated under back-pressure shows up in the index and data comparison.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_EMIT,
    ST_FIN
  } rxu_state_e;

  function automatic logic [2:0] bytes_per_word(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rxu_ctrl.sv
module rxu_ctrl
  import rxu_pkg::*;
#(
  parameter int WCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WCNT_W-1:0] num_words,
  input  logic              fifo_not_empty,
  input  logic              step,
  input  logic              last_byte,
  output rxu_state_e        state,
  output logic              go,
  output logic              fifo_pop,
  output logic              capture,
  output logic              emit,
  output logic              done,
  output logic              busy,
  output logic              ran_dry
);
  rxu_state_e        nxt;
  logic [WCNT_W-1:0] words_left;
  logic              more;

  assign go       = start && (state == ST_IDLE);
  assign more     = (words_left != '0);
  assign fifo_pop = (state == ST_CHECK) && more && fifo_not_empty;
  assign capture  = (state == ST_WAIT);
  assign emit     = (state == ST_EMIT);
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (go) nxt = ST_CHECK;
      ST_CHECK: begin
        if (!more || !fifo_not_empty) nxt = ST_FIN;
        else                          nxt = ST_WAIT;
      end
      ST_WAIT:  nxt = ST_EMIT;
      ST_EMIT:  if (step && last_byte) nxt = ST_CHECK;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      words_left <= '0;
      ran_dry    <= 1'b0;
    end else begin
      state <= nxt;
      if (go) begin
        words_left <= num_words;
        ran_dry    <= 1'b0;
      end else if (emit && step && last_byte) begin
        words_left <= words_left - 1'b1;
      end
      if (state == ST_CHECK && more && !fifo_not_empty) ran_dry <= 1'b1;
    end
  end
endmodule

// File: rtl/rxu_lane.sv
module rxu_lane
  import rxu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        step,
  input  logic [1:0]  size_code,
  input  logic [31:0] rdata,
  output logic [7:0]  cur_byte,
  output logic        last_byte
);
  logic [31:0] sh;
  logic [2:0]  left;

  assign cur_byte  = sh[31:24];
  assign last_byte = (left == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (capture) begin
      left <= bytes_per_word(size_code);
      case (size_code)
        2'd0:    sh <= {rdata[7:0], 24'h0};
        2'd1:    sh <= {rdata[15:0], 16'h0};
        default: sh <= rdata;
      endcase
    end else if (step) begin
      sh   <= {sh[23:0], 8'h0};
      left <= left - 3'd1;
    end
  end
endmodule

// File: rtl/rxu_limit.sv
module rxu_limit #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             emit,
  input  logic [POS_W-1:0] len,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] delivered,
  output logic             step
);
  logic keep;

  assign keep      = (pos < len);
  assign out_valid = emit && keep;
  assign step      = emit && (!keep || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      delivered <= '0;
    end else if (clear) begin
      pos       <= '0;
      delivered <= '0;
    end else if (step) begin
      pos <= pos + 1'b1;
      if (keep) delivered <= delivered + 1'b1;
    end
  end
endmodule

// File: rtl/rx_unpack.sv
module rx_unpack
  import rxu_pkg::*;
#(
  parameter int WCNT_W = 6,
  localparam int POS_W = WCNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        word_size,
  input  logic [WCNT_W-1:0] num_words,
  input  logic [POS_W-1:0]  rx_len,
  input  logic              fifo_not_empty,
  output logic              fifo_pop,
  input  logic [31:0]       fifo_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic [POS_W-1:0]  out_index,
  output logic              busy,
  output logic              done,
  output logic [POS_W-1:0]  delivered,
  output logic              ran_dry
);
  rxu_state_e       state;
  logic             go, capture, emit, step, last_byte;
  logic [1:0]       size_q;
  logic [POS_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      len_q  <= '0;
    end else if (go) begin
      size_q <= word_size;
      len_q  <= rx_len;
    end
  end

  rxu_ctrl #(.WCNT_W(WCNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .num_words(num_words),
    .fifo_not_empty(fifo_not_empty), .step(step), .last_byte(last_byte),
    .state(state), .go(go), .fifo_pop(fifo_pop), .capture(capture),
    .emit(emit), .done(done), .busy(busy), .ran_dry(ran_dry)
  );

  rxu_lane u_lane (
    .clk(clk), .rst_n(rst_n), .capture(capture), .step(step),
    .size_code(size_q), .rdata(fifo_rdata), .cur_byte(out_byte),
    .last_byte(last_byte)
  );

  rxu_limit #(.POS_W(POS_W)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(go), .emit(emit), .len(len_q),
    .out_ready(out_ready), .out_valid(out_valid), .pos(out_index),
    .delivered(delivered), .step(step)
  );
endmodule

// File: rtl/rx_unpack_chk.sv
module rx_unpack_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_pop,
  input logic             fifo_not_empty,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic [POS_W-1:0] out_index,
  input logic             done,
  input logic             busy,
  input logic [POS_W-1:0] delivered,
  input logic [POS_W-1:0] len_q
);
  assert_pop_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_not_empty);

  assert_no_back_to_back_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_index)));

  assert_index_below_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_index < len_q));

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_delivered_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    delivered <= len_q);
endmodule

bind rx_unpack rx_unpack_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_pop(fifo_pop), .fifo_not_empty(fifo_not_empty),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
  .out_index(out_index), .done(done), .busy(busy), .delivered(delivered),
  .len_q(len_q)
);

// File: tb/tb_rx_unpack.sv
`timescale 1ns/1ps
module tb_rx_unpack;
  localparam int WCNT_W = 6;
  localparam int POS_W  = WCNT_W + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] word_size = 0;
  logic [WCNT_W-1:0] num_words = 0;
  logic [POS_W-1:0] rx_len = 0;
  logic fifo_not_empty, fifo_pop, out_valid, out_ready, busy, done, ran_dry;
  logic [31:0] fifo_rdata = 0;
  logic [7:0] out_byte;
  logic [POS_W-1:0] out_index, delivered;

  always #2 clk = ~clk;

  rx_unpack #(.WCNT_W(WCNT_W)) dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [16];
  int rd = 0, fill = 0;
  logic tb_clr = 0;
  assign fifo_not_empty = (rd < fill);
  always @(posedge clk) begin
    if (tb_clr) rd <= 0;
    else if (fifo_pop) begin
      fifo_rdata <= mem[rd[3:0]];
      rd <= rd + 1;
    end
  end

  logic [7:0] lfsr = 8'h5A;
  logic stall_mode = 0;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? lfsr[0] : 1'b1;
  end

  logic [7:0] got_b [64];
  int got_i [64];
  int n_got = 0, n_pop = 0;
  logic prev_pop = 0, dbl_pop = 0;
  always @(negedge clk) begin
    if (out_valid && out_ready && n_got < 64) begin
      got_b[n_got] = out_byte;
      got_i[n_got] = int'(out_index);
      n_got = n_got + 1;
    end
    if (fifo_pop) n_pop = n_pop + 1;
    if (fifo_pop && prev_pop) dbl_pop = 1;
    prev_pop = fifo_pop;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int code, input int nw, input int len, input int avail, input int seed);
    int nb, eff, total, exp_del, waited;
    string lane;
    nb = (code == 0) ? 1 : (code == 1) ? 2 : 4;
    lane = (code == 0) ? "R1" : (code == 1) ? "R2" : "R3";
    @(posedge clk); #1;
    tb_clr = 1;
    fill = avail;
    for (int i = 0; i < 16; i++) mem[i] = (32'h9E3779B1 * (i + 1 + seed)) ^ (seed << 8);
    @(posedge clk); #1;
    tb_clr = 0;
    n_got = 0; n_pop = 0; dbl_pop = 0;
    word_size = code[1:0]; num_words = nw[WCNT_W-1:0]; rx_len = len[POS_W-1:0];
    start = 1;
    @(posedge clk); #1;
    start = 0;
    waited = 0;
    do begin @(negedge clk); waited++; end while (!done && waited < 2000);
    eff = (nw < avail) ? nw : avail;
    total = eff * nb;
    exp_del = (len < total) ? len : total;
    chk("R7 done seen", int'(done), 1);
    chk("R8 delivered", int'(delivered), exp_del);
    chk("R4 ran_dry", int'(ran_dry), (avail < nw) ? 1 : 0);
    @(negedge clk);
    chk("R7 done pulse width", int'(done), 0);
    chk("R7 busy after done", int'(busy), 0);
    chk("R8 delivered holds", int'(delivered), exp_del);
    chk("R5 pop count", n_pop, eff);
    chk("R10 no consecutive pops", int'(dbl_pop), 0);
    chk("R6 byte count", n_got, exp_del);
    for (int k = 0; k < exp_del && k < n_got; k++) begin
      logic [31:0] w;
      int b;
      w = mem[k / nb];
      b = k % nb;
      chk(lane, int'(got_b[k]), int'((w >> (8 * (nb - 1 - b))) & 32'hFF));
      chk("R6 index", got_i[k], k);
    end
  endtask

  initial begin
    out_ready = 1;
    #9;
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 out_valid", int'(out_valid), 0);
    chk("R11 fifo_pop", int'(fifo_pop), 0);
    chk("R11 ran_dry", int'(ran_dry), 0);
    chk("R11 delivered", int'(delivered), 0);
    rst_n = 1;
    begin
      int seed;
      seed = 0;
      for (int code = 0; code < 4; code++)
        for (int nw = 0; nw < 6; nw++)
          for (int li = 0; li < 5; li++)
            for (int half = 0; half < 2; half++) begin
              int nb, tot, len, avail;
              nb = (code == 0) ? 1 : (code == 1) ? 2 : 4;
              tot = nw * nb;
              case (li)
                0: len = 0;
                1: len = 1;
                2: len = (tot > 0) ? tot - 1 : 0;
                3: len = tot;
                default: len = tot + 3;
              endcase
              avail = half ? nw / 2 : nw;
              stall_mode = seed[0];
              run_case(code, nw, len, avail, seed);
              seed++;
            end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule